// File: doc/BRIEF.md
# Gate Control List Executor

This block runs a time-aware transmission schedule. It takes a free-running seconds/nanoseconds clock and produces one gate bit per traffic class, where 1 means the class may transmit and 0 means it is held back. The schedule is a list of rows. Each row holds a gate mask and an interval. The list starts at a programmed base time and repeats at every cycle time. Rows run one after another. Once the programmed number of rows has run, all gates close until the cycle ends. If the rows add up to more than the cycle time, the list is cut off at the cycle boundary.

There are two row banks. Software fills one bank and its shadow timing registers through an indirect select/row/data write port. Hardware executes from the other bank. A commit request locks the shadow set and reports the block as busy. If the requested start time has already passed, the block moves it forward by whole cycles. It then waits until the start time and swaps the banks. At that swap the current list is cut short, unless the old cycle has a normal end that falls just before the new start. In that case the old cycle is stretched so that it ends exactly at the new start. The block also reports the next row's gates and duration, and the time left in the current row, for use by a transmit scheduler.

Top module: `gcl_exec`

FSM states: `ST_IDLE` (no list installed, all gates open), `ST_ROW` (a row is executing) and `ST_HOLD` (rows exhausted, gates closed until the cycle ends). Transitions: IDLE to ROW on install; ROW to ROW on a row advance, a cycle restart or an install; ROW to HOLD after the last row; HOLD to ROW on a cycle restart or an install. A stretch keeps the current state and moves only the cycle end. The programming side has the states `P_OPEN`, `P_FIX` and `P_READY`. OPEN goes to FIX on commit. FIX goes to READY once the start time is not in the past. READY goes to OPEN when the list is installed.

## Requirements
- R1: After reset, gate_now and gate_next are all ones, row_left_ns and next_row_ns are 0, and busy, sw_bank, wr_reject, err_base and err_const are all 0.
- R2: The write port uses these select codes: 0 writes a row, 1 sets the start nanoseconds, 2 sets the start seconds, 3 sets the cycle nanoseconds, 4 sets the cycle seconds (8 bits), 5 sets the stretch limit in ns, 6 sets the length (bits LL_W-1:0) and the shift (bits 18:16), and 7 commits. A row word carries the interval in bits TI_W-1:0 and the gates in bits TI_W+NTC-1:TI_W.
- R3: While no list is installed, gates stay all open. A committed list starts at its start time with row 0.
- R4: Row k lasts (interval << shift) ns, and rows advance in order 0,1,2,... row_left_ns is the time left in the current row. gate_next and next_row_ns describe the following row, which wraps to row 0 after the last row.
- R5: After the last row ends, gate_now is 0 until the cycle ends.
- R6: Cycle N starts at start + N*cycle and always restarts at row 0. This also holds when the rows have not all finished.
- R7: busy is 1 from commit until install. At install, sw_bank toggles, and the bank software just filled becomes the executing bank.
- R8: When the new start time is reached in the middle of a cycle, the old list is cut short and the new list's row 0 begins.
- R9: If an old cycle ends earlier than the new start time, but by fewer ns than the stretch limit, no new old cycle begins. The current gates are held until the new start time.
- R10: A commit whose start time lies in the past sets err_base. The start time advances by whole cycles to the first value that is not earlier than the current time. Each commit clears err_base.
- R11: A commit with length 1 and a shifted row-0 interval greater than or equal to the cycle time sets err_const. Each commit clears err_const.
- R12: A row write to the executing bank, or any write while busy, is rejected. wr_reject pulses one cycle later, and the rejected write has no effect on the schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| time_sec | input | 32 | Current time, seconds part |
| time_ns | input | 32 | Current time, nanoseconds part |
| cfg_we | input | 1 | Write strobe |
| cfg_sel | input | 3 | Register select (R2) |
| cfg_bank | input | 1 | Target bank for row writes |
| cfg_row | input | AW | Target row index |
| cfg_wdata | input | 32 | Write data |
| gate_now | output | NTC | Current gate vector |
| gate_next | output | NTC | Gates of the following row |
| row_left_ns | output | 32 | Time left in the current row |
| next_row_ns | output | TI_W+7 | Duration of the following row |
| sw_bank | output | 1 | Bank owned by software |
| busy | output | 1 | Commit pending |
| wr_reject | output | 1 | Last write was rejected |
| err_base | output | 1 | Start time was in the past |
| err_const | output | 1 | Constant-gate configuration |

## Verification
The bench targets boundaries that sit exactly on a row end or a cycle end. Treating a boundary as open-ended there would show the previous row one step too long. A list whose rows outrun the cycle is checked for a restart at row 0; a design without truncation would keep showing the long second row. A swap is placed just after an old cycle end that lies within the stretch limit; a design without the stretch would briefly restart row 0 of the old list. A start time in the past and rejected writes to the running bank are also checked, because a design without catch-up would wait forever and one without write rejection would corrupt the running schedule.

// File: rtl/gcl_pkg.sv
package gcl_pkg;

    typedef enum logic [2:0] {
        SEL_ROW      = 3'd0,
        SEL_BASE_NS  = 3'd1,
        SEL_BASE_SEC = 3'd2,
        SEL_CYC_NS   = 3'd3,
        SEL_CYC_SEC  = 3'd4,
        SEL_EXT      = 3'd5,
        SEL_LEN      = 3'd6,
        SEL_COMMIT   = 3'd7
    } cfg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ROW,
        ST_HOLD
    } run_st_e;

    typedef enum logic [1:0] {
        P_OPEN,
        P_FIX,
        P_READY
    } prog_st_e;

    // seconds/nanoseconds pair to a flat nanosecond count
    function automatic logic [63:0] flat_ns(input logic [31:0] sec, input logic [31:0] ns);
        return ({32'd0, sec} * 64'd1000000000) + {32'd0, ns};
    endfunction

endpackage

// File: rtl/gcl_row_store.sv
module gcl_row_store #(
    parameter int NTC   = 8,
    parameter int TI_W  = 16,
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic            wr_bank,
    input  logic [AW-1:0]   wr_idx,
    input  logic [NTC-1:0]  wr_gate,
    input  logic [TI_W-1:0] wr_ti,
    input  logic            hw_bank,
    input  logic [AW-1:0]   cur_idx,
    input  logic [AW-1:0]   nxt_idx,
    output logic [NTC-1:0]  cur_gate,
    output logic [NTC-1:0]  nxt_gate,
    output logic [TI_W-1:0] nxt_ti,
    output logic [TI_W-1:0] hw0_ti,
    output logic [TI_W-1:0] sw0_ti
);

    logic [NTC-1:0]  bk_cur_gate [2];
    logic [NTC-1:0]  bk_nxt_gate [2];
    logic [TI_W-1:0] bk_nxt_ti   [2];
    logic [TI_W-1:0] bk_row0_ti  [2];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [NTC-1:0]  gq [DEPTH];
        logic [TI_W-1:0] tq [DEPTH];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) begin
                    gq[i] <= '0;
                    tq[i] <= '0;
                end
            end else if (we && (wr_bank == 1'(b))) begin
                gq[wr_idx] <= wr_gate;
                tq[wr_idx] <= wr_ti;
            end
        end

        assign bk_cur_gate[b] = gq[cur_idx];
        assign bk_nxt_gate[b] = gq[nxt_idx];
        assign bk_nxt_ti[b]   = tq[nxt_idx];
        assign bk_row0_ti[b]  = tq[0];
    end

    assign cur_gate = bk_cur_gate[hw_bank];
    assign nxt_gate = bk_nxt_gate[hw_bank];
    assign nxt_ti   = bk_nxt_ti[hw_bank];
    assign hw0_ti   = bk_row0_ti[hw_bank];
    assign sw0_ti   = bk_row0_ti[~hw_bank];

    AST_HW_BANK_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (wr_bank != hw_bank)) else $error("write reached executing bank"); // R12

endmodule

// File: rtl/gcl_prog_port.sv
module gcl_prog_port
    import gcl_pkg::*;
#(
    parameter int NTC  = 8,
    parameter int TI_W = 16,
    parameter int AW   = 4,
    parameter int LL_W = 5,
    parameter int IV_W = TI_W + 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [2:0]      cfg_sel,
    input  logic            cfg_bank,
    input  logic [AW-1:0]   cfg_row,
    input  logic [31:0]     cfg_wdata,
    input  logic [63:0]     now_ns,
    input  logic [TI_W-1:0] row0_ti,
    input  logic            swap_done,
    output logic            mem_we,
    output logic            mem_bank,
    output logic [AW-1:0]   mem_idx,
    output logic [NTC-1:0]  mem_gate,
    output logic [TI_W-1:0] mem_ti,
    output logic            sw_bank,
    output logic            busy,
    output logic            wr_reject,
    output logic            err_base,
    output logic            err_const,
    output logic            pend_ready,
    output logic [63:0]     pend_base,
    output logic [63:0]     pend_cycle,
    output logic [LL_W-1:0] pend_len,
    output logic [2:0]      pend_shift,
    output logic [IV_W-1:0] pend_ext
);

    prog_st_e        p_st;
    logic [31:0]     base_sec_q, base_ns_q, cyc_ns_q;
    logic [7:0]      cyc_sec_q;
    logic [63:0]     pb_q, pc_q;
    logic            accept, is_row, is_commit;
    logic [63:0]     cyc_flat;
    logic [IV_W-1:0] row0_iv;

    assign is_row    = (cfg_sel_e'(cfg_sel) == SEL_ROW);
    assign is_commit = (cfg_sel_e'(cfg_sel) == SEL_COMMIT);
    assign accept    = cfg_we && (p_st == P_OPEN) && !(is_row && (cfg_bank != sw_bank));
    assign cyc_flat  = flat_ns({24'd0, cyc_sec_q}, cyc_ns_q);
    assign row0_iv   = IV_W'(row0_ti) << pend_shift;

    assign mem_we    = accept && is_row;
    assign mem_bank  = cfg_bank;
    assign mem_idx   = cfg_row;
    assign mem_gate  = cfg_wdata[TI_W +: NTC];
    assign mem_ti    = cfg_wdata[TI_W-1:0];

    assign busy       = (p_st != P_OPEN);
    assign pend_ready = (p_st == P_READY);
    assign pend_base  = pb_q;
    assign pend_cycle = pc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_st       <= P_OPEN;
            base_sec_q <= '0;
            base_ns_q  <= '0;
            cyc_ns_q   <= '0;
            cyc_sec_q  <= '0;
            pend_ext   <= '0;
            pend_len   <= '0;
            pend_shift <= '0;
            pb_q       <= '0;
            pc_q       <= '0;
            sw_bank    <= 1'b0;
            wr_reject  <= 1'b0;
            err_base   <= 1'b0;
            err_const  <= 1'b0;
        end else begin
            wr_reject <= cfg_we && !accept;
            unique case (p_st)
                P_OPEN: begin
                    if (accept) begin
                        unique case (cfg_sel_e'(cfg_sel))
                            SEL_ROW:      ;
                            SEL_BASE_NS:  base_ns_q  <= cfg_wdata;
                            SEL_BASE_SEC: base_sec_q <= cfg_wdata;
                            SEL_CYC_NS:   cyc_ns_q   <= cfg_wdata;
                            SEL_CYC_SEC:  cyc_sec_q  <= cfg_wdata[7:0];
                            SEL_EXT:      pend_ext   <= cfg_wdata[IV_W-1:0];
                            SEL_LEN: begin
                                pend_len   <= cfg_wdata[LL_W-1:0];
                                pend_shift <= cfg_wdata[18:16];
                            end
                            SEL_COMMIT: begin
                                pb_q      <= flat_ns(base_sec_q, base_ns_q);
                                pc_q      <= cyc_flat;
                                err_base  <= 1'b0;
                                err_const <= (pend_len == LL_W'(1)) && (64'(row0_iv) >= cyc_flat);
                                p_st      <= P_FIX;
                            end
                        endcase
                    end
                end
                P_FIX: begin
                    if ((pb_q < now_ns) && (pc_q != 64'd0)) begin
                        pb_q     <= pb_q + pc_q;
                        err_base <= 1'b1;
                    end else begin
                        p_st <= P_READY;
                    end
                end
                P_READY: begin
                    if (swap_done) begin
                        sw_bank <= ~sw_bank;
                        p_st    <= P_OPEN;
                    end
                end
                default: p_st <= P_OPEN;
            endcase
        end
    end

    AST_SWAP_ONLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
        swap_done |-> (p_st == P_READY)) else $error("install without ready list"); // R7
    AST_OWNER_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        swap_done |=> (sw_bank != $past(sw_bank))) else $error("ownership not handed over"); // R7
    AST_START_NOT_PAST: assert property (@(posedge clk) disable iff (!rst_n)
        ((p_st == P_READY) && ($past(p_st) == P_FIX)) |-> ((pb_q >= $past(now_ns)) || (pc_q == 64'd0)))
        else $error("start time left in the past"); // R10

endmodule

// File: rtl/gcl_exec.sv
module gcl_exec
    import gcl_pkg::*;
#(
    parameter int NTC   = 8,
    parameter int TI_W  = 16,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int LL_W = $clog2(DEPTH) + 1,
    localparam int IV_W = TI_W + 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [31:0]     time_sec,
    input  logic [31:0]     time_ns,
    input  logic            cfg_we,
    input  logic [2:0]      cfg_sel,
    input  logic            cfg_bank,
    input  logic [AW-1:0]   cfg_row,
    input  logic [31:0]     cfg_wdata,
    output logic [NTC-1:0]  gate_now,
    output logic [NTC-1:0]  gate_next,
    output logic [31:0]     row_left_ns,
    output logic [IV_W-1:0] next_row_ns,
    output logic            sw_bank,
    output logic            busy,
    output logic            wr_reject,
    output logic            err_base,
    output logic            err_const
);

    logic [63:0]     now_ns;
    logic            hw_bank;
    logic            mem_we, mem_bank, pend_ready, swap_go;
    logic [AW-1:0]   mem_idx, nxt_idx;
    logic [NTC-1:0]  mem_gate, cur_gate, nxt_gate;
    logic [TI_W-1:0] mem_ti, nxt_ti, hw0_ti, sw0_ti;
    logic [63:0]     pend_base, pend_cycle;
    logic [LL_W-1:0] pend_len;
    logic [2:0]      pend_shift;
    logic [IV_W-1:0] pend_ext;

    run_st_e         st, st_d;
    logic [AW-1:0]   idx, idx_d;
    logic [63:0]     row_end, row_end_d, cyc_end, cyc_end_d, a_cycle, a_cycle_d;
    logic [LL_W-1:0] a_len, a_len_d, idx_p1;
    logic [2:0]      a_shift, a_shift_d;
    logic [IV_W-1:0] a_ext, a_ext_d;
    logic [IV_W-1:0] nxt_iv, hw0_iv, sw0_iv;
    logic            last_row, cyc_hit, row_hit, do_ext;
    logic [63:0]     gap, left_full;

    assign now_ns   = flat_ns(time_sec, time_ns);
    assign hw_bank  = ~sw_bank;
    assign idx_p1   = LL_W'(idx) + LL_W'(1);
    assign last_row = (idx_p1 >= a_len);
    assign nxt_idx  = last_row ? '0 : AW'(idx_p1);
    assign nxt_iv   = IV_W'(nxt_ti) << a_shift;
    assign hw0_iv   = IV_W'(hw0_ti) << a_shift;
    assign sw0_iv   = IV_W'(sw0_ti) << pend_shift;

    gcl_row_store #(.NTC(NTC), .TI_W(TI_W), .DEPTH(DEPTH), .AW(AW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (mem_we),
        .wr_bank  (mem_bank),
        .wr_idx   (mem_idx),
        .wr_gate  (mem_gate),
        .wr_ti    (mem_ti),
        .hw_bank  (hw_bank),
        .cur_idx  (idx),
        .nxt_idx  (nxt_idx),
        .cur_gate (cur_gate),
        .nxt_gate (nxt_gate),
        .nxt_ti   (nxt_ti),
        .hw0_ti   (hw0_ti),
        .sw0_ti   (sw0_ti)
    );

    gcl_prog_port #(.NTC(NTC), .TI_W(TI_W), .AW(AW), .LL_W(LL_W), .IV_W(IV_W)) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_bank   (cfg_bank),
        .cfg_row    (cfg_row),
        .cfg_wdata  (cfg_wdata),
        .now_ns     (now_ns),
        .row0_ti    (sw0_ti),
        .swap_done  (swap_go),
        .mem_we     (mem_we),
        .mem_bank   (mem_bank),
        .mem_idx    (mem_idx),
        .mem_gate   (mem_gate),
        .mem_ti     (mem_ti),
        .sw_bank    (sw_bank),
        .busy       (busy),
        .wr_reject  (wr_reject),
        .err_base   (err_base),
        .err_const  (err_const),
        .pend_ready (pend_ready),
        .pend_base  (pend_base),
        .pend_cycle (pend_cycle),
        .pend_len   (pend_len),
        .pend_shift (pend_shift),
        .pend_ext   (pend_ext)
    );

    // schedule events seen this cycle
    assign swap_go = pend_ready && (now_ns >= pend_base);
    assign cyc_hit = (st != ST_IDLE) && (now_ns >= cyc_end);
    assign row_hit = (st == ST_ROW) && (now_ns >= row_end);
    assign gap     = pend_base - cyc_end;
    assign do_ext  = pend_ready && (pend_base > cyc_end) && (gap < 64'(a_ext));

    // next-state process
    always_comb begin
        st_d      = st;
        idx_d     = idx;
        row_end_d = row_end;
        cyc_end_d = cyc_end;
        a_cycle_d = a_cycle;
        a_len_d   = a_len;
        a_shift_d = a_shift;
        a_ext_d   = a_ext;
        if (swap_go) begin
            st_d      = ST_ROW;
            idx_d     = '0;
            row_end_d = pend_base + 64'(sw0_iv);
            cyc_end_d = pend_base + pend_cycle;
            a_cycle_d = pend_cycle;
            a_len_d   = pend_len;
            a_shift_d = pend_shift;
            a_ext_d   = pend_ext;
        end else if (cyc_hit) begin
            if (do_ext) begin
                cyc_end_d = pend_base;
            end else begin
                st_d      = ST_ROW;
                idx_d     = '0;
                row_end_d = cyc_end + 64'(hw0_iv);
                cyc_end_d = cyc_end + a_cycle;
            end
        end else if (row_hit) begin
            if (last_row) begin
                st_d = ST_HOLD;
            end else begin
                idx_d     = nxt_idx;
                row_end_d = row_end + 64'(nxt_iv);
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            idx     <= '0;
            row_end <= '0;
            cyc_end <= '0;
            a_cycle <= '0;
            a_len   <= '0;
            a_shift <= '0;
            a_ext   <= '0;
        end else begin
            st      <= st_d;
            idx     <= idx_d;
            row_end <= row_end_d;
            cyc_end <= cyc_end_d;
            a_cycle <= a_cycle_d;
            a_len   <= a_len_d;
            a_shift <= a_shift_d;
            a_ext   <= a_ext_d;
        end
    end

    // outputs
    assign left_full = row_end - now_ns;

    always_comb begin
        unique case (st)
            ST_IDLE: begin
                gate_now    = '1;
                gate_next   = '1;
                row_left_ns = '0;
                next_row_ns = '0;
            end
            ST_ROW: begin
                gate_now    = cur_gate;
                gate_next   = nxt_gate;
                next_row_ns = nxt_iv;
                if (now_ns >= row_end)
                    row_left_ns = '0;
                else if (|left_full[63:32])
                    row_left_ns = '1;
                else
                    row_left_ns = left_full[31:0];
            end
            ST_HOLD: begin
                gate_now    = '0;
                gate_next   = nxt_gate;
                row_left_ns = '0;
                next_row_ns = nxt_iv;
            end
            default: begin
                gate_now    = '1;
                gate_next   = '1;
                row_left_ns = '0;
                next_row_ns = '0;
            end
        endcase
    end

    AST_IDX_BELOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |-> (LL_W'(idx) < a_len)) else $error("row index past list length"); // R4
    AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_ROW) && ($past(st) == ST_ROW) && (idx != $past(idx)))
        |-> ((idx == '0) || (idx == $past(idx) + AW'(1)))) else $error("row skipped"); // R4
    AST_HOLD_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_HOLD) && ($past(st) == ST_ROW)) |-> ($past(now_ns) >= $past(row_end)))
        else $error("gates closed early"); // R5
    AST_CYCLE_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        ((st != ST_IDLE) && ($past(st) != ST_IDLE) && !$past(swap_go) && (cyc_end != $past(cyc_end)))
        |-> (cyc_end > $past(cyc_end))) else $error("cycle end moved backwards"); // R6

endmodule

// File: tb/gcl_exec_tb_top.sv
module gcl_exec_tb_top;

    localparam int NTC = 8;
    localparam int TI_W = 16;
    localparam int DEPTH = 16;
    localparam int AW = $clog2(DEPTH);
    localparam int IV_W = TI_W + 7;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [31:0]     time_sec = 32'd10;
    logic [31:0]     time_ns = 32'd0;
    logic            cfg_we = 1'b0;
    logic [2:0]      cfg_sel = '0;
    logic            cfg_bank = 1'b0;
    logic [AW-1:0]   cfg_row = '0;
    logic [31:0]     cfg_wdata = '0;
    logic [NTC-1:0]  gate_now, gate_next;
    logic [31:0]     row_left_ns;
    logic [IV_W-1:0] next_row_ns;
    logic            sw_bank, busy, wr_reject, err_base, err_const;

    int n_checks = 0;
    int n_fails = 0;
    bit reported = 0;

    typedef struct {
        string  tag;
        int     g;
        int     n;
        longint left;
        longint dur;
    } exp_t;

    exp_t exp_q[$];
    event mon_ev;

    always #10 clk = ~clk;

    gcl_exec #(.NTC(NTC), .TI_W(TI_W), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .time_sec(time_sec), .time_ns(time_ns),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_bank(cfg_bank), .cfg_row(cfg_row),
        .cfg_wdata(cfg_wdata), .gate_now(gate_now), .gate_next(gate_next),
        .row_left_ns(row_left_ns), .next_row_ns(next_row_ns), .sw_bank(sw_bank),
        .busy(busy), .wr_reject(wr_reject), .err_base(err_base), .err_const(err_const)
    );

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        end
    endtask

    task automatic chk(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // monitor: pops expected schedule outputs and compares
    initial begin
        forever begin
            @(mon_ev);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk({e.tag, " gate_now"}, longint'(gate_now), longint'(e.g));
                chk({e.tag, " gate_next"}, longint'(gate_next), longint'(e.n));
                if (e.left >= 0) chk({e.tag, " row_left_ns"}, longint'(row_left_ns), e.left);
                if (e.dur >= 0) chk({e.tag, " next_row_ns"}, longint'(next_row_ns), e.dur);
            end
        end
    end

    task automatic expect_out(input string tag, input int g, input int n, input longint left, input longint dur);
        exp_t e;
        e.tag = tag; e.g = g; e.n = n; e.left = left; e.dur = dur;
        exp_q.push_back(e);
        ->mon_ev;
        #1;
    endtask

    task automatic set_time(input int ns);
        @(negedge clk);
        time_ns = ns;
        repeat (4) @(negedge clk);
    endtask

    task automatic wr(input int sel, input bit bank, input int row, input int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_bank = bank;
        cfg_row = AW'(row); cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic row(input bit bank, input int r, input int gates, input int ti);
        wr(0, bank, r, (gates << TI_W) | ti);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out("R1 reset", 'hFF, 'hFF, 0, 0);
        chk("R1 busy", busy, 0);
        chk("R1 sw_bank", sw_bank, 0);
        chk("R1 err_base", err_base, 0);
        chk("R1 err_const", err_const, 0);
        chk("R1 wr_reject", wr_reject, 0);

        // bank 1 is executing-side at reset: write rejected
        row(1, 0, 'hAA, 5);
        chk("R12 reject exec bank", wr_reject, 1);

        // list 1 into bank 0 (R2 encodings)
        row(0, 0, 'h81, 100);
        chk("R2 row accepted", wr_reject, 0);
        row(0, 1, 'h42, 200);
        row(0, 2, 'h24, 50);
        wr(1, 0, 0, 1000);
        wr(2, 0, 0, 10);
        wr(3, 0, 0, 500);
        wr(4, 0, 0, 0);
        wr(5, 0, 0, 0);
        wr(6, 0, 0, 3);
        wr(7, 0, 0, 0);
        @(negedge clk);
        chk("R7 busy after commit", busy, 1);
        chk("R10 no base error", err_base, 0);

        set_time(999);
        expect_out("R3 before start", 'hFF, 'hFF, 0, 0);
        set_time(1000);
        expect_out("R3 start row0", 'h81, 'h42, 100, 200);
        chk("R7 sw_bank after install", sw_bank, 1);
        chk("R7 busy cleared", busy, 0);
        set_time(1050);
        expect_out("R4 row0 mid", 'h81, 'h42, 50, 200);
        set_time(1100);
        expect_out("R4 row1", 'h42, 'h24, 200, 50);
        set_time(1300);
        expect_out("R4 row2", 'h24, 'h81, 50, 100);
        set_time(1350);
        expect_out("R5 hold closed", 'h00, 'h81, 0, 100);
        set_time(1500);
        expect_out("R6 cycle 1", 'h81, 'h42, 100, 200);

        row(0, 0, 'h11, 7);
        chk("R12 reject running bank", wr_reject, 1);
        set_time(1600);
        expect_out("R4 row1 cycle1", 'h42, 'h24, 200, 50);
        set_time(2000);
        expect_out("R12 row0 unchanged", 'h81, 'h42, 100, 200);

        // list 2 into bank 1, shift 1, rows longer than cycle
        row(1, 0, 'h0F, 100);
        row(1, 1, 'hF0, 250);
        wr(1, 0, 0, 3200);
        wr(3, 0, 0, 600);
        wr(5, 0, 0, 100);
        wr(6, 0, 0, 2 | (1 << 16));
        wr(7, 0, 0, 0);
        @(negedge clk);
        chk("R7 busy list2", busy, 1);

        set_time(3000);
        expect_out("R6 cycle at 3000", 'h81, 'h42, 100, 200);
        set_time(3150);
        expect_out("R4 row1 at 3150", 'h42, 'h24, 150, 50);
        set_time(3200);
        expect_out("R8 cut to new list", 'h0F, 'hF0, 200, 500);
        chk("R7 sw_bank list2", sw_bank, 0);
        set_time(3400);
        expect_out("R4 shifted row1", 'hF0, 'h0F, 500, 200);
        set_time(3800);
        expect_out("R6 truncated restart", 'h0F, 'hF0, 200, 500);

        // list 3 into bank 0, start 50 ns past an old cycle end
        row(0, 0, 'h33, 1000);
        wr(1, 0, 0, 4450);
        wr(3, 0, 0, 2000);
        wr(5, 0, 0, 0);
        wr(6, 0, 0, 1);
        wr(7, 0, 0, 0);
        @(negedge clk);
        chk("R11 no const error", err_const, 0);

        set_time(4000);
        expect_out("R4 row1 list2", 'hF0, 'h0F, 500, 200);
        set_time(4400);
        expect_out("R9 old cycle stretched", 'hF0, 'h0F, 100, 200);
        set_time(4450);
        expect_out("R9 new list at start", 'h33, 'h33, 1000, 1000);

        // list 4 into bank 1 with start in the past
        set_time(4500);
        expect_out("R4 list3 running", 'h33, 'h33, 950, 1000);
        row(1, 0, 'h55, 300);
        wr(1, 0, 0, 4000);
        wr(3, 0, 0, 1000);
        wr(6, 0, 0, 1);
        wr(7, 0, 0, 0);
        repeat (4) @(negedge clk);
        chk("R10 base error", err_base, 1);
        chk("R10 busy pending", busy, 1);
        set_time(4999);
        expect_out("R10 not yet", 'h33, 'h33, -1, 1000);
        set_time(5000);
        expect_out("R10 advanced start", 'h55, 'h55, 300, 300);
        chk("R7 sw_bank list4", sw_bank, 0);

        // list 5 into bank 0: constant gate
        row(0, 0, 'h66, 800);
        wr(2, 0, 0, 20);
        wr(3, 0, 0, 800);
        wr(6, 0, 0, 1);
        wr(7, 0, 0, 0);
        repeat (3) @(negedge clk);
        chk("R11 const error", err_const, 1);
        chk("R10 base error cleared", err_base, 0);
        row(0, 1, 'h77, 9);
        chk("R12 reject while busy", wr_reject, 1);
        set_time(5100);
        expect_out("R12 schedule unaffected", 'h55, 'h55, 200, 300);

        repeat (2) @(negedge clk);
        report();
        $finish;
    end

endmodule